// File: doc/BRIEF.md
# Serial Access Register Port

This block is the serial side of a dual-ported video-style memory. It keeps one row's worth of bytes (256 entries of 8 bits by default) in a register bank and walks through it with a wrap-around pointer. Each serial step advances the pointer by one. Depending on the current direction, the step either presents the addressed byte on the serial output or stores the serial input byte at the addressed entry. An active-low serial enable controls access. In output mode it gates the output drive. In input mode it gates the store.

The bank exchanges whole rows with the main array through transfer commands. A command carries a kind, a starting tap address and, for loads, the row contents. Each kind behaves differently:

- A read transfer loads the bank from the row and switches the port to output.
- A real-time read does the same, but lets the old row keep streaming while the transfer is in flight.
- A write transfer presents the bank contents as a row to be stored and switches the port to input.
- A pseudo write only switches the port to input.

Every transfer restarts the pointer at its tap. Serial steps that arrive during a transfer other than a real-time read are discarded and flagged as a protocol error.

Top module: `serial_tap_port`

## Requirements
- R1: After reset the pointer is 0, the pointer is marked invalid (`ptrValid`=0), the port is in input mode (`isInput`=1), no transfer is in progress, and `serOe`, `seqErr` and `rowWrite` are 0.
- R2: A serial step accepted while no transfer is in progress advances `tapPtr` by one in the next cycle, wrapping from DEPTH-1 to 0.
- R3: The pointer advances on an accepted step whatever the value of `serEnN` and whatever the direction.
- R4: A `xferStart` accepted while idle makes `xferBusy` high for exactly XFER_CYCLES cycles. In the cycle after `xferBusy` falls, `tapPtr` equals the tap given with that start and `ptrValid` is 1. A `xferStart` while busy is ignored.
- R5: A read transfer (`xferType`=0) loads entry i of the bank from `rowIn[i*DW +: DW]`, sampled in the last busy cycle. It then puts the port in output mode (`isInput`=0).
- R6: A write transfer (`xferType`=2) raises `rowWrite` for one cycle, in the cycle right after busy ends. During that cycle `rowOut[i*DW +: DW]` holds bank entry i, and the port is in input mode. A pseudo write (`xferType`=3) sets input mode, leaves the bank unchanged and never raises `rowWrite`.
- R7: In output mode with a valid pointer, `serOe` equals the inverse of `serEnN`. While `serOe` is 1, `serOut` shows the bank entry at `tapPtr`.
- R8: In input mode, an accepted step stores `serIn` at entry `tapPtr` only when `serEnN` is 0. With `serEnN` at 1 the entry keeps its value.
- R9: During a real-time read (`xferType`=1), steps keep advancing through the old contents without an error. At the end the new row is in place and `serOut` shows the new entry at the tap with no idle step.
- R10: A serial step during any other transfer raises `seqErr` in the next cycle. It neither moves the pointer nor writes the bank.
- R11: Before the first completed transfer, `serOe` stays 0 whatever `serEnN` is, while steps still advance the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serStep | input | 1 | One-cycle strobe marking a serial clock rising edge |
| serEnN | input | 1 | Active-low serial enable (output drive or store) |
| serIn | input | DW | Serial input byte |
| serOut | output | DW | Serial output byte (bank entry at the pointer) |
| serOe | output | 1 | Serial output drive enable |
| xferStart | input | 1 | Transfer command strobe |
| xferType | input | 2 | 0 read, 1 real-time read, 2 write, 3 pseudo write |
| xferTap | input | PW | Starting tap for the transfer |
| rowIn | input | DEPTH*DW | Row contents for read transfers |
| rowOut | output | DEPTH*DW | Bank contents, entry i at bits i*DW |
| rowWrite | output | 1 | One-cycle strobe: store `rowOut` into the row |
| xferBusy | output | 1 | Transfer in progress |
| tapPtr | output | PW | Current serial pointer |
| ptrValid | output | 1 | A transfer has completed since reset |
| isInput | output | 1 | Port direction: 1 input, 0 output |
| seqErr | output | 1 | One-cycle pulse: step arrived during a transfer |

## Verification
The directed part starts a read at tap 250 and steps across the wrap with `serEnN` both low and high. This separates pointer motion from output gating, and a wrong modulus or gated pointer shows up as a wrong tap. It then mixes stores with `serEnN` low and high under a pseudo write and reads them back through a write transfer's `rowOut`, which shows whether each byte was stored or held. Steps are placed inside a real-time read and inside a plain read, together with a second start, to tell streaming from error rejection and to show that the first tap wins. A long pseudo-random mix of steps, enables and transfers of all four kinds is then compared every cycle against a behavioural reference model.

// File: rtl/stp_pkg.sv
package stp_pkg;

  // Transfer kinds; the encoding is visible on the xferType port.
  typedef enum logic [1:0] {
    XFER_READ   = 2'd0,
    XFER_RTREAD = 2'd1,
    XFER_WRITE  = 2'd2,
    XFER_PSEUDO = 2'd3
  } xfer_kind_e;

  // Strobes from the sequencer to the register bank.
  typedef struct packed {
    logic shiftEn;   // advance pointer
    logic writeEn;   // store serial input at pointer
    logic loadRow;   // load whole bank from row input
    logic loadTap;   // reload pointer with held tap
  } dp_ctl_t;

endpackage

// File: rtl/stp_ctrl.sv
module stp_ctrl
  import stp_pkg::*;
#(
  parameter int PW          = 8,
  parameter int XFER_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          serStep,
  input  logic          serEnN,
  input  logic          xferStart,
  input  logic [1:0]    xferType,
  input  logic [PW-1:0] xferTap,
  output dp_ctl_t       ctl,
  output logic [PW-1:0] tapHold,
  output logic          xferBusy,
  output logic          ptrValid,
  output logic          isInput,
  output logic          serOe,
  output logic          seqErr,
  output logic          rowWrite
);

  localparam int CW = $clog2(XFER_CYCLES + 1);

  logic [CW-1:0] cntQ;
  xfer_kind_e    kindQ;
  logic          xferDone;
  logic          rtKind;
  logic          stepOk;

  assign xferBusy = (cntQ != '0);
  assign xferDone = (cntQ == CW'(1));
  assign rtKind   = (kindQ == XFER_RTREAD);

  // Steps pass while idle, or while a real-time read streams the old row.
  assign stepOk = serStep && (!xferBusy || rtKind);

  always_comb begin
    ctl.shiftEn = stepOk;
    ctl.writeEn = stepOk && !xferBusy && isInput && !serEnN && ptrValid;
    ctl.loadTap = xferDone;
    ctl.loadRow = xferDone && ((kindQ == XFER_READ) || (kindQ == XFER_RTREAD));
  end

  assign serOe = ptrValid && !isInput && !serEnN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ     <= '0;
      kindQ    <= XFER_READ;
      tapHold  <= '0;
      ptrValid <= 1'b0;
      isInput  <= 1'b1;
      seqErr   <= 1'b0;
      rowWrite <= 1'b0;
    end else begin
      seqErr   <= serStep && xferBusy && !rtKind;
      rowWrite <= xferDone && (kindQ == XFER_WRITE);
      if (!xferBusy && xferStart) begin
        cntQ    <= CW'(XFER_CYCLES);
        kindQ   <= xfer_kind_e'(xferType);
        tapHold <= xferTap;
      end else if (xferBusy) begin
        cntQ <= cntQ - CW'(1);
      end
      if (xferDone) begin
        ptrValid <= 1'b1;
        isInput  <= (kindQ == XFER_WRITE) || (kindQ == XFER_PSEUDO);
      end
    end
  end

endmodule

// File: rtl/stp_dpath.sv
module stp_dpath
  import stp_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dp_ctl_t             ctl,
  input  logic [PW-1:0]       tapHold,
  input  logic [DW-1:0]       serIn,
  input  logic [DEPTH*DW-1:0] rowIn,
  output logic [DW-1:0]       serOut,
  output logic [PW-1:0]       tapPtr,
  output logic [DEPTH*DW-1:0] rowOut
);

  logic [PW-1:0] ptrQ;
  logic [DW-1:0] cellArr [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ptrQ <= '0;
    else if (ctl.loadTap) ptrQ <= tapHold;
    else if (ctl.shiftEn) ptrQ <= ptrQ + PW'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gCell
    logic [DW-1:0] cellQ;
    always_ff @(posedge clk) begin
      if (ctl.loadRow)                               cellQ <= rowIn[g*DW +: DW];
      else if (ctl.writeEn && (ptrQ == PW'(g)))      cellQ <= serIn;
    end
    assign cellArr[g]         = cellQ;
    assign rowOut[g*DW +: DW] = cellQ;
  end

  assign serOut = cellArr[ptrQ];
  assign tapPtr = ptrQ;

endmodule

// File: rtl/serial_tap_port.sv
module serial_tap_port
  import stp_pkg::*;
#(
  parameter int DW          = 8,
  parameter int DEPTH       = 256,
  parameter int XFER_CYCLES = 4,
  parameter int PW          = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serStep,
  input  logic                serEnN,
  input  logic [DW-1:0]       serIn,
  output logic [DW-1:0]       serOut,
  output logic                serOe,
  input  logic                xferStart,
  input  logic [1:0]          xferType,
  input  logic [PW-1:0]       xferTap,
  input  logic [DEPTH*DW-1:0] rowIn,
  output logic [DEPTH*DW-1:0] rowOut,
  output logic                rowWrite,
  output logic                xferBusy,
  output logic [PW-1:0]       tapPtr,
  output logic                ptrValid,
  output logic                isInput,
  output logic                seqErr
);

  dp_ctl_t       ctl;
  logic [PW-1:0] tapHold;

  stp_ctrl #(.PW(PW), .XFER_CYCLES(XFER_CYCLES)) uCtrl (
    .clk, .rstN, .serStep, .serEnN, .xferStart, .xferType, .xferTap,
    .ctl, .tapHold, .xferBusy, .ptrValid, .isInput, .serOe, .seqErr, .rowWrite
  );

  stp_dpath #(.DW(DW), .DEPTH(DEPTH), .PW(PW)) uDpath (
    .clk, .rstN, .ctl, .tapHold, .serIn, .rowIn, .serOut, .tapPtr, .rowOut
  );

endmodule

// File: rtl/stp_checker.sv
module stp_checker #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          serStep,
  input logic          xferStart,
  input logic [1:0]    xferType,
  input logic [PW-1:0] xferTap,
  input logic          xferBusy,
  input logic [PW-1:0] tapPtr,
  input logic          ptrValid,
  input logic          isInput,
  input logic          serOe,
  input logic          seqErr,
  input logic          rowWrite
);

  // Own record of the accepted command.
  logic          rtSeen;
  logic [PW-1:0] tapSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rtSeen  <= 1'b0;
      tapSeen <= '0;
    end else if (xferStart && !xferBusy) begin
      rtSeen  <= (xferType == 2'd1);
      tapSeen <= xferTap;
    end
  end

  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (serStep && !xferBusy) |=> (tapPtr == $past(tapPtr) + PW'(1)));

  assert_tap_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(xferBusy) |-> (tapPtr == tapSeen) && ptrValid);

  assert_rowwr_after_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    rowWrite |-> (!xferBusy && $past(xferBusy)));

  assert_no_drive_input_R8: assert property (@(posedge clk) disable iff (!rstN)
    isInput |-> !serOe);

  assert_busy_step_err_R10: assert property (@(posedge clk) disable iff (!rstN)
    (serStep && xferBusy && !rtSeen) |=> seqErr);

  assert_err_only_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    seqErr |-> $past(xferBusy));

  assert_no_drive_invalid_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ptrValid |-> !serOe);

endmodule

bind serial_tap_port stp_checker #(.PW(PW)) uChk (.*);

// File: tb/tb_serial_tap_port.sv
`timescale 1ns/1ps
module tb_serial_tap_port;

  localparam int DW = 8;
  localparam int DEPTH = 256;
  localparam int NX = 4;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serStep = 1'b0, serEnN = 1'b1, xferStart = 1'b0;
  logic [DW-1:0] serIn = '0;
  logic [1:0] xferType = '0;
  logic [PW-1:0] xferTap = '0;
  logic [DEPTH*DW-1:0] rowIn = '0;
  logic [DW-1:0] serOut;
  logic serOe, rowWrite, xferBusy, ptrValid, isInput, seqErr;
  logic [DEPTH*DW-1:0] rowOut;
  logic [PW-1:0] tapPtr;

  always #2 clk = ~clk;

  serial_tap_port #(.DW(DW), .DEPTH(DEPTH), .XFER_CYCLES(NX)) dut (.*);

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // Behavioural reference model
  int mReg [DEPTH];
  bit mKnown [DEPTH];
  int mPtr, mCnt, mType, mTap;
  bit mValid, mInput, mErr, mRowWr;

  always @(posedge clk) begin
    if (!rstN) begin
      mPtr = 0; mCnt = 0; mType = 0; mTap = 0;
      mValid = 0; mInput = 1; mErr = 0; mRowWr = 0;
      foreach (mKnown[i]) mKnown[i] = 0;
    end else begin
      bit busy, done, stepOk;
      busy = (mCnt != 0);
      done = (mCnt == 1);
      stepOk = serStep && (!busy || mType == 1);
      mErr = serStep && busy && (mType != 1);
      mRowWr = done && (mType == 2);
      if (stepOk && !busy && mInput && !serEnN && mValid) begin
        mReg[mPtr] = serIn; mKnown[mPtr] = 1;
      end
      if (done) mPtr = mTap;
      else if (stepOk) mPtr = (mPtr + 1) % DEPTH;
      if (done) begin
        if (mType <= 1)
          for (int i = 0; i < DEPTH; i++) begin
            mReg[i] = rowIn[i*DW +: DW]; mKnown[i] = 1;
          end
        mInput = (mType >= 2);
        mValid = 1;
      end
      if (!busy && xferStart) begin
        mCnt = NX; mType = xferType; mTap = xferTap;
      end else if (busy) mCnt = mCnt - 1;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmpAll();
    bit eOe;
    eOe = mValid && !mInput && !serEnN;
    chk(tapPtr == mPtr, "R2 pointer", tapPtr, mPtr);
    chk(ptrValid == mValid, "R4 ptrValid", ptrValid, mValid);
    chk(xferBusy == (mCnt != 0), "R4 busy", xferBusy, mCnt != 0);
    chk(isInput == mInput, "R5 direction", isInput, mInput);
    chk(seqErr == mErr, "R10 seqErr", seqErr, mErr);
    chk(rowWrite == mRowWr, "R6 rowWrite", rowWrite, mRowWr);
    chk(serOe == eOe, "R7 serOe", serOe, eOe);
    if (eOe && mKnown[mPtr])
      chk(serOut == mReg[mPtr], "R7 serOut", serOut, mReg[mPtr]);
    if (mRowWr) begin
      int bad = 0;
      for (int i = 0; i < DEPTH; i++)
        if (mKnown[i] && rowOut[i*DW +: DW] != mReg[i]) bad++;
      chk(bad == 0, "R6 rowOut mismatches", bad, 0);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cmpAll();
  endtask

  task automatic drive(bit st, bit enN, int din, bit xs, int typ, int tap);
    serStep = st; serEnN = enN; serIn = DW'(din);
    xferStart = xs; xferType = 2'(typ); xferTap = PW'(tap);
    tick();
  endtask

  function automatic int fRow(int i); return (i * 7 + 3) & 255; endfunction
  function automatic int gRow(int i); return 255 - i; endfunction

  task automatic fillRow(bit useG);
    for (int i = 0; i < DEPTH; i++) rowIn[i*DW +: DW] = DW'(useG ? gRow(i) : fRow(i));
  endtask

  task automatic doXfer(int typ, int tap);
    drive(0, serEnN, 0, 1, typ, tap);
    repeat (NX) drive(0, serEnN, 0, 0, 0, 0);
  endtask

  initial begin
    #((200000) * 4);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog R1..all actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int lf;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk(tapPtr == 0, "R1 pointer", tapPtr, 0);
    chk(ptrValid == 0, "R1 ptrValid", ptrValid, 0);
    chk(isInput == 1, "R1 isInput", isInput, 1);
    chk(!xferBusy && !serOe && !seqErr && !rowWrite, "R1 idle outputs", 1, 0);

    // R11: steps before any transfer advance pointer, no drive
    repeat (3) drive(1, 0, 0, 0, 0, 0);
    chk(tapPtr == 3, "R11 pointer advance", tapPtr, 3);
    chk(serOe == 0, "R11 no drive", serOe, 0);

    // R5: read transfer at tap 250
    fillRow(0);
    serEnN = 0;
    doXfer(0, 250);
    chk(tapPtr == 250, "R4 tap load", tapPtr, 250);
    chk(isInput == 0, "R5 output mode", isInput, 0);
    chk(serOe == 1 && serOut == fRow(250), "R5 loaded entry", serOut, fRow(250));

    // R2 wrap, R3 disabled steps
    repeat (10) drive(1, 0, 0, 0, 0, 0);
    chk(tapPtr == 4, "R2 wrap", tapPtr, 4);
    chk(serOut == fRow(4), "R7 serOut after wrap", serOut, fRow(4));
    repeat (3) drive(1, 1, 0, 0, 0, 0);
    chk(tapPtr == 7, "R3 advance while disabled", tapPtr, 7);
    chk(serOe == 0, "R7 enable high blocks drive", serOe, 0);

    // R6 pseudo write, R8 gated stores
    doXfer(3, 5);
    chk(isInput == 1 && tapPtr == 5, "R6 pseudo sets input", tapPtr, 5);
    drive(1, 0, 8'hA1, 0, 0, 0);
    drive(1, 1, 8'hB2, 0, 0, 0);
    drive(1, 0, 8'hC3, 0, 0, 0);
    chk(tapPtr == 8, "R3 pointer in input mode", tapPtr, 8);
    doXfer(2, 0);
    chk(rowWrite == 1, "R6 rowWrite pulse", rowWrite, 1);
    chk(rowOut[5*DW +: DW] == 8'hA1, "R8 stored byte", rowOut[5*DW +: DW], 8'hA1);
    chk(rowOut[6*DW +: DW] == fRow(6), "R8 disabled store held", rowOut[6*DW +: DW], fRow(6));
    chk(rowOut[7*DW +: DW] == 8'hC3, "R8 second store", rowOut[7*DW +: DW], 8'hC3);
    chk(rowOut[100*DW +: DW] == fRow(100), "R6 pseudo kept bank", rowOut[100*DW +: DW], fRow(100));
    drive(0, 0, 0, 0, 0, 0);
    chk(rowWrite == 0, "R6 single pulse", rowWrite, 0);

    // R9 real-time read
    doXfer(0, 10);
    fillRow(1);
    drive(1, 0, 0, 1, 1, 20);
    repeat (NX) begin
      drive(1, 0, 0, 0, 0, 0);
      chk(seqErr == 0, "R9 no error while streaming", seqErr, 0);
    end
    chk(tapPtr == 20 && serOut == gRow(20), "R9 new row at tap", serOut, gRow(20));
    drive(1, 0, 0, 0, 0, 0);
    chk(tapPtr == 21 && serOut == gRow(21), "R9 next entry", serOut, gRow(21));

    // R10 step during plain read, R4 second start ignored
    fillRow(0);
    drive(0, 0, 0, 1, 0, 3);
    drive(1, 0, 0, 0, 0, 0);
    chk(seqErr == 1, "R10 error pulse", seqErr, 1);
    chk(tapPtr == 21, "R10 pointer held", tapPtr, 21);
    drive(0, 0, 0, 1, 2, 99);
    repeat (NX - 2) drive(0, 0, 0, 0, 0, 0);
    chk(tapPtr == 3 && isInput == 0, "R4 busy start ignored", tapPtr, 3);

    // Pseudo-random mix
    lf = 32'h1ACE;
    for (int k = 0; k < 3000; k++) begin
      lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
      if ((lf % 29) == 0) for (int i = 0; i < DEPTH; i++) rowIn[i*DW +: DW] = DW'((i * k + lf) & 255);
      drive(lf[0], lf[3] & lf[5], lf & 255, (lf % 23) == 0, (lf >> 4) & 3, (lf >> 7) & 255);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule